// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block is a register-access front end that sits behind two byte-wide host ports. The index port is at a base address and the data port is at base plus one. A configuration register is reached by writing its number to the index port and then reading or writing the data port. None of this is possible until the host has written an unlock key to the index port on two writes in a row. A separate exit key locks the port again. While the port is locked, index writes only feed the key detector.

One global register picks a logical device. The registers from 0x30 upward are banked, so each logical device has its own copy, and bit 0 of the first banked register activates that device. A second global register returns a fixed chip identifier. Each device is a small register stub. Every banked write is also sent, one cycle later, to a downstream strobe interface that carries the device number, the index and the data, so that real logical devices can be attached.

Top module: `cfgport_top`

## Requirements
- R1: Reset leaves the port locked (`cfg_mode` = 0), the device selector at 0, every banked register at 0 (so `dev_active` is all zeros), `ld_wstb` low and `bus_rdata` at 0xFF.
- R2: Two index-port writes of 0x87 in a row set `cfg_mode` in the cycle after the second write; a single 0x87 does not.
- R3: An index-port write of any value other than 0x87 after the first key write restarts the unlock sequence, so two further 0x87 writes are then needed.
- R4: An index-port write of 0xAA while unlocked clears `cfg_mode` in the next cycle.
- R5: While locked, data-port writes change no register and raise no strobe, and reads of either port return 0xFF.
- R6: The index port responds only at `BASE_ADDR` and the data port only at `BASE_ADDR`+1. Accesses to any other address have no effect and leave `bus_rdata` unchanged. A read of the unlocked index port returns the current index.
- R7: A read of either port loads `bus_rdata` at the clock edge that samples `bus_rd`, and `bus_rdata` holds that value until the next port read.
- R8: Index 0x07 is the logical-device selector: it can be read and written as a full byte.
- R9: Index 0x20 reads `CHIP_ID`, and writes to it are ignored.
- R10: Indices 0x30 up to 0x30+`BANK_REGS`-1 are banked. Each device number below `NUM_DEV` keeps its own values. For a device number of `NUM_DEV` or above, writes store nothing and reads return 0x00.
- R11: `dev_active[d]` equals bit 0 of banked register 0x30 of device d, and it changes only in the cycle after an unlocked data-port write.
- R12: Each unlocked data-port write to a banked index drives `ld_wstb` high for one cycle, in the next cycle, with the device number on `ld_num`, the index on `ld_index` and the data on `ld_wdata`. Other writes raise no strobe.
- R13: A read of any index that is not 0x07, not 0x20 and not in the banked window returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host port address |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| cfg_mode | output | 1 | High while the port is unlocked |
| dev_active | output | NUM_DEV | Activate bit of each logical device |
| ld_wstb | output | 1 | Downstream banked-write strobe |
| ld_num | output | 8 | Device number of the strobed write |
| ld_index | output | 8 | Register index of the strobed write |
| ld_wdata | output | 8 | Data of the strobed write |

## Verification
Every result of this block is due exactly one cycle after its stimulus. The lock state, the selector and the banked registers change at the edge that samples the write. `bus_rdata` is loaded at the edge that samples the read. `ld_wstb` and its fields are registered from the write, so they are visible in the following cycle and gone one cycle after that. The bench drives each access on a falling edge, holds it for one cycle, and samples the outputs on the next falling edge. That falls after the single register stage and before the next edge could change anything. The strobe is checked a second time one further cycle later to confirm that it was a single pulse.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   localparam logic [7:0] KEY_ENTER  = 8'h87;
   localparam logic [7:0] KEY_EXIT   = 8'hAA;
   localparam logic [7:0] IDX_LDN    = 8'h07;
   localparam logic [7:0] IDX_CHIPID = 8'h20;
   localparam logic [7:0] IDX_BANK0  = 8'h30;
   localparam logic [7:0] RD_LOCKED  = 8'hFF;
   localparam logic [7:0] RD_UNMAPPED = 8'h00;

   typedef enum logic [1:0] {
      LK_LOCKED = 2'd0,
      LK_HALF   = 2'd1,
      LK_OPEN   = 2'd2
   } lock_state_e;

   typedef struct packed {
      logic       stb;
      logic [7:0] num;
      logic [7:0] idx;
      logic [7:0] data;
   } ld_req_t;

endpackage

// File: rtl/cfg_unlock.sv
module cfg_unlock
   import cfgport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       open,
   output logic       idx_load
);

   lock_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (idx_wr) begin
         case (state_q)
            LK_LOCKED: if (wdata == KEY_ENTER) state_d = LK_HALF;
            LK_HALF:   state_d = (wdata == KEY_ENTER) ? LK_OPEN : LK_LOCKED;
            LK_OPEN:   if (wdata == KEY_EXIT) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= LK_LOCKED;
      else        state_q <= state_d;
   end

   assign open     = (state_q == LK_OPEN);
   assign idx_load = idx_wr && open && (wdata != KEY_EXIT);

endmodule

// File: rtl/cfg_global.sv
module cfg_global
   import cfgport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_load,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   output logic [7:0] index_q,
   output logic [7:0] ldn_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= 8'h00;
         ldn_q   <= 8'h00;
      end else begin
         if (idx_load) index_q <= wdata;
         if (data_wr && (index_q == IDX_LDN)) ldn_q <= wdata;
      end
   end

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank #(
   parameter int NUM_DEV   = 10,
   parameter int BANK_REGS = 16,
   localparam int OFF_W    = $clog2(BANK_REGS),
   localparam int DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [7:0]         dev,
   input  logic [OFF_W-1:0]   off,
   input  logic [7:0]         wdata,
   output logic [7:0]         rdata,
   output logic [NUM_DEV-1:0] active
);

   logic             dev_ok;
   logic [DEV_W-1:0] dev_idx;
   logic [7:0]       dev_rd [NUM_DEV];

   assign dev_ok  = (32'(dev) < NUM_DEV);
   assign dev_idx = dev[DEV_W-1:0];

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      logic [7:0] regs [BANK_REGS];
      logic       sel;

      assign sel = wr_en && dev_ok && (dev_idx == DEV_W'(d));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int r = 0; r < BANK_REGS; r++) regs[r] <= 8'h00;
         end else if (sel) begin
            regs[off] <= wdata;
         end
      end

      assign dev_rd[d] = regs[off];
      assign active[d] = regs[0][0];
   end

   assign rdata = dev_ok ? dev_rd[dev_idx] : 8'h00;

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
   import cfgport_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2E,
   parameter logic [7:0]        CHIP_ID   = 8'hA5,
   parameter int                NUM_DEV   = 10,
   parameter int                BANK_REGS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic               cfg_mode,
   output logic [NUM_DEV-1:0] dev_active,
   output logic               ld_wstb,
   output logic [7:0]         ld_num,
   output logic [7:0]         ld_index,
   output logic [7:0]         ld_wdata
);

   localparam int                OFF_W  = $clog2(BANK_REGS);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(BASE_ADDR + 1'b1);
   localparam int                BANK_END = 32'(IDX_BANK0) + BANK_REGS;

   if (NUM_DEV < 1 || NUM_DEV > 256) begin : g_bad_dev
      $error("NUM_DEV must lie in 1..256");
   end
   if (BANK_REGS < 2 || BANK_REGS > 208) begin : g_bad_bank
      $error("BANK_REGS must lie in 2..208");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic       hit_idx, hit_dat;
   logic       idx_wr, data_wr, idx_load;
   logic [7:0] index_q, ldn_q;
   logic       in_bank;
   logic [7:0] bank_off;
   logic [7:0] bank_rd;
   logic [7:0] data_val, rd_next;
   ld_req_t    req_q;

   assign hit_idx = (bus_addr == BASE_ADDR);
   assign hit_dat = (bus_addr == DATA_A);
   assign idx_wr  = bus_wr && hit_idx;
   assign data_wr = bus_wr && hit_dat && cfg_mode;

   cfg_unlock u_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (idx_wr),
      .wdata    (bus_wdata),
      .open     (cfg_mode),
      .idx_load (idx_load)
   );

   cfg_global u_global (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_load (idx_load),
      .data_wr  (data_wr),
      .wdata    (bus_wdata),
      .index_q  (index_q),
      .ldn_q    (ldn_q)
   );

   assign in_bank  = (index_q >= IDX_BANK0) && (32'(index_q) < BANK_END);
   assign bank_off = index_q - IDX_BANK0;

   cfg_dev_bank #(
      .NUM_DEV   (NUM_DEV),
      .BANK_REGS (BANK_REGS)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (data_wr && in_bank),
      .dev    (ldn_q),
      .off    (bank_off[OFF_W-1:0]),
      .wdata  (bus_wdata),
      .rdata  (bank_rd),
      .active (dev_active)
   );

   always_comb begin
      if (index_q == IDX_LDN)         data_val = ldn_q;
      else if (index_q == IDX_CHIPID) data_val = CHIP_ID;
      else if (in_bank)               data_val = bank_rd;
      else                            data_val = RD_UNMAPPED;
   end

   always_comb begin
      if (!cfg_mode)    rd_next = RD_LOCKED;
      else if (hit_idx) rd_next = index_q;
      else              rd_next = data_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                         bus_rdata <= RD_LOCKED;
      else if (bus_rd && (hit_idx || hit_dat)) bus_rdata <= rd_next;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
      end else begin
         req_q.stb <= data_wr && in_bank;
         if (data_wr && in_bank) begin
            req_q.num  <= ldn_q;
            req_q.idx  <= index_q;
            req_q.data <= bus_wdata;
         end
      end
   end

   assign ld_wstb  = req_q.stb;
   assign ld_num   = req_q.num;
   assign ld_index = req_q.idx;
   assign ld_wdata = req_q.data;

endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2E,
   parameter logic [7:0]        CHIP_ID   = 8'hA5,
   parameter int                NUM_DEV   = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [7:0]         bus_wdata,
   input logic [7:0]         bus_rdata,
   input logic               cfg_mode,
   input logic [NUM_DEV-1:0] dev_active,
   input logic               ld_wstb,
   input logic [7:0]         cur_index
);

   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(BASE_ADDR + 1'b1);

   assert_enter_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_mode) |-> $past(bus_wr && bus_addr == BASE_ADDR && bus_wdata == 8'h87));

   assert_exit_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && bus_wr && bus_addr == BASE_ADDR && bus_wdata == 8'hAA) |=> !cfg_mode);

   assert_locked_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && bus_rd && (bus_addr == BASE_ADDR || bus_addr == DATA_A)) |=> bus_rdata == 8'hFF);

   assert_chip_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && bus_rd && bus_addr == DATA_A && cur_index == 8'h20) |=> bus_rdata == CHIP_ID);

   assert_active_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_mode && bus_wr && bus_addr == DATA_A) |=> $stable(dev_active));

   assert_strobe_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ld_wstb |-> $past(cfg_mode && bus_wr && bus_addr == DATA_A));

endmodule

bind cfgport_top cfgport_checker #(
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR),
   .CHIP_ID   (CHIP_ID),
   .NUM_DEV   (NUM_DEV)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .cfg_mode   (cfg_mode),
   .dev_active (dev_active),
   .ld_wstb    (ld_wstb),
   .cur_index  (index_q)
);

// File: tb/cfgport_top_bench.sv
module cfgport_top_bench;

   localparam int          CLK_PERIOD = 10;
   localparam int          ADDR_W     = 16;
   localparam logic [15:0] BASE       = 16'h002E;
   localparam logic [7:0]  CID        = 8'hB7;
   localparam int          NDEV       = 10;
   localparam int          NBANK      = 16;
   localparam int          NV         = 23;

   // {op, data, expected}: op 0 index write, 1 data write, 2 data read, 3 index read
   localparam logic [17:0] VEC [NV] = '{
      {2'd3, 8'h00, 8'hFF}, {2'd0, 8'h87, 8'h00}, {2'd0, 8'h87, 8'h00},
      {2'd0, 8'h07, 8'h00}, {2'd1, 8'h08, 8'h00}, {2'd2, 8'h00, 8'h08},
      {2'd0, 8'h30, 8'h00}, {2'd1, 8'h5A, 8'h00}, {2'd2, 8'h00, 8'h5A},
      {2'd3, 8'h00, 8'h30}, {2'd0, 8'h07, 8'h00}, {2'd1, 8'h03, 8'h00},
      {2'd0, 8'h30, 8'h00}, {2'd2, 8'h00, 8'h00}, {2'd1, 8'hC3, 8'h00},
      {2'd2, 8'h00, 8'hC3}, {2'd0, 8'h20, 8'h00}, {2'd2, 8'h00, CID},
      {2'd0, 8'h3F, 8'h00}, {2'd1, 8'h11, 8'h00}, {2'd2, 8'h00, 8'h11},
      {2'd0, 8'h40, 8'h00}, {2'd2, 8'h00, 8'h00}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [7:0]        bus_wdata = 8'h00;
   logic [7:0]        bus_rdata;
   logic              cfg_mode;
   logic [NDEV-1:0]   dev_active;
   logic              ld_wstb;
   logic [7:0]        ld_num, ld_index, ld_wdata;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgport_top #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE),
      .CHIP_ID   (CID),
      .NUM_DEV   (NDEV),
      .BANK_REGS (NBANK)
   ) u_cfgport_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cfg_mode   (cfg_mode),
      .dev_active (dev_active),
      .ld_wstb    (ld_wstb),
      .ld_num     (ld_num),
      .ld_index   (ld_index),
      .ld_wdata   (ld_wdata)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic raw_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic raw_rd(input logic [ADDR_W-1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic wi(input logic [7:0] d); raw_wr(BASE, d); endtask
   task automatic wd(input logic [7:0] d); raw_wr(BASE + 16'd1, d); endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cfg_mode", 16'(cfg_mode), 16'd0);
      chk("R1 rdata", 16'(bus_rdata), 16'hFF);
      chk("R1 dev_active", 16'(dev_active), 16'd0);
      chk("R1 ld_wstb", 16'(ld_wstb), 16'd0);

      // vector table: R7/R8/R10/R13 with R2 unlock at its head
      for (int i = 0; i < NV; i++) begin
         case (VEC[i][17:16])
            2'd0: wi(VEC[i][15:8]);
            2'd1: wd(VEC[i][15:8]);
            2'd2: begin raw_rd(BASE + 16'd1, v); chk("R7/R8/R10/R13 table data", 16'(v), 16'(VEC[i][7:0])); end
            default: begin raw_rd(BASE, v); chk("R6/R7 table index", 16'(v), 16'(VEC[i][7:0])); end
         endcase
      end
      chk("R11 after table", 16'(dev_active), 16'h008);

      // R11 and R12: activate device 8
      wi(8'h07); wd(8'h08); wi(8'h30); wd(8'h01);
      chk("R12 strobe", 16'(ld_wstb), 16'd1);
      chk("R12 num", 16'(ld_num), 16'h08);
      chk("R12 index", 16'(ld_index), 16'h30);
      chk("R12 data", 16'(ld_wdata), 16'h01);
      chk("R11 active", 16'(dev_active), 16'h108);
      @(negedge clk);
      chk("R12 single pulse", 16'(ld_wstb), 16'd0);

      // R9: chip id is read-only, no strobe
      wi(8'h20); wd(8'h00);
      chk("R12 no strobe global", 16'(ld_wstb), 16'd0);
      raw_rd(BASE + 16'd1, v);
      chk("R9 chip id", 16'(v), 16'(CID));

      // R10: device out of range
      wi(8'h07); wd(8'h0C); wi(8'h30); wd(8'hFF);
      chk("R12 strobe any dev", 16'(ld_wstb), 16'd1);
      chk("R12 num oob", 16'(ld_num), 16'h0C);
      raw_rd(BASE + 16'd1, v);
      chk("R10 oob read", 16'(v), 16'h00);
      chk("R10 oob active", 16'(dev_active), 16'h108);
      wi(8'h07);
      raw_rd(BASE + 16'd1, v);
      chk("R8 ldn full byte", 16'(v), 16'h0C);

      // R6: foreign address has no effect
      wd(8'h08); wi(8'h30);
      raw_wr(BASE + 16'd2, 8'h77);
      raw_rd(BASE + 16'd1, v);
      chk("R6 foreign write", 16'(v), 16'h01);
      raw_rd(BASE + 16'd2, v);
      chk("R6 foreign read holds", 16'(v), 16'h01);

      // R4 exit, R5 locked behaviour
      wi(8'hAA);
      chk("R4 exit", 16'(cfg_mode), 16'd0);
      wd(8'hEE);
      chk("R5 no strobe", 16'(ld_wstb), 16'd0);
      chk("R5 active held", 16'(dev_active), 16'h108);
      raw_rd(BASE + 16'd1, v);
      chk("R5 data read", 16'(v), 16'hFF);
      raw_rd(BASE, v);
      chk("R5 index read", 16'(v), 16'hFF);

      // R2 and R3: key sequence
      wi(8'h87);
      chk("R2 single key", 16'(cfg_mode), 16'd0);
      wi(8'h12); wi(8'h87);
      chk("R3 restart", 16'(cfg_mode), 16'd0);
      wi(8'h87);
      chk("R2 enter", 16'(cfg_mode), 16'd1);
      raw_rd(BASE + 16'd1, v);
      chk("R5 locked write ignored", 16'(v), 16'h01);

      // R1: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 re cfg_mode", 16'(cfg_mode), 16'd0);
      chk("R1 re active", 16'(dev_active), 16'd0);
      chk("R1 re rdata", 16'(bus_rdata), 16'hFF);
      wi(8'h87); wi(8'h87); wi(8'h07);
      raw_rd(BASE + 16'd1, v);
      chk("R1 ldn zero", 16'(v), 16'h00);
      wi(8'h30);
      raw_rd(BASE + 16'd1, v);
      chk("R1 bank zero", 16'(v), 16'h00);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule